// File: doc/BRIEF.md
# Serial CRC-4 Check Generator for Read Transactions

This block produces the 4-bit check value that a reader compares against the check bits a tag returns after a read. A read transaction is described by three items: a read flag (always 1), the byte address, and the data byte that came back. The block packs these into one bit string. It then runs a 4-bit CRC over that string, one bit per clock cycle, least-significant bit first.

The address field can be 5, 8 or 10 bits wide. A two-bit size selector picks the width, so the packed string is 14, 17 or 19 bits long. A one-cycle start strobe captures all inputs. After the string has been processed, the block registers the result and raises a done flag for one cycle. The result stays on the output until the next run completes. A new start strobe always begins a fresh run, even in the middle of a run that has not finished.

Top module: `cmd_crc4`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `crc_o` is 0 and `done_o` is 0.
- R2: The packed string has the read flag 1 in bit 0. The address occupies bits A:1, where A is the selected address width. The data byte occupies bits A+8:A+1. Address input bits at or above A are not used.
- R3: The CRC register is loaded with 0x5. For each string bit, least significant first, the register is updated as follows. First, the feedback is taken as register bit 0 XOR the input bit. Then the register shifts right by one, with a 0 entering bit 3. Finally, the register is XORed with 0xC when the feedback is 1. The final register value is output with no final XOR.
- R4: The size selector `asz_i` uses this encoding: 0 selects a 5-bit address (14 string bits), 1 selects 8 bits (17 string bits), and 2 selects 10 bits (19 string bits).
- R5: The start strobe is sampled at some clock edge. The string length is L. `done_o` is high for exactly one cycle, following the L-th clock edge after the sampling edge.
- R6: `crc_o` changes only in a cycle where `done_o` is high, and it holds its value otherwise.
- R7: A start strobe with `asz_i` = 3 is ignored. No run begins, no done pulse follows, and `crc_o` keeps its value.
- R8: A valid start strobe during a run abandons that run. This also holds on the edge that would have finished the run. The abandoned run produces no done pulse. Only the new run reports, with its own timing and value.
- R9: The address, data and size inputs are captured on the start edge. Changes to them during a run do not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle strobe that begins a run |
| asz_i | input | 2 | Address size selector (0: 5 bits, 1: 8 bits, 2: 10 bits, 3: reserved) |
| addr_i | input | 10 | Byte address |
| data_i | input | 8 | Returned data byte |
| crc_o | output | 4 | Registered CRC result |
| done_o | output | 1 | One-cycle pulse when `crc_o` has been updated |

## Verification
Two events can fall on the same clock edge: a fresh start strobe, and the processing of the final bit of the run in progress. The bench provokes this by launching a second transaction on the exact edge where the first would complete. It also launches one five cycles into a run. Each case is judged correct when no done pulse appears for the abandoned run, and a single pulse arrives at the second run's full latency carrying the second run's CRC. Random address and data values are compared against a bench model of the packing and the CRC update.

// File: rtl/crc4_pkg.sv
package crc4_pkg;
  typedef enum logic [1:0] {
    ASZ_SHORT = 2'd0,
    ASZ_MID   = 2'd1,
    ASZ_LONG  = 2'd2,
    ASZ_RSVD  = 2'd3
  } asz_e;
endpackage

// File: rtl/crc4_pack.sv
module crc4_pack
  import crc4_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 8,
  parameter int A_SHORT = 5,
  parameter int A_MID   = 8,
  parameter int PACK_W  = ADDR_W + DATA_W + 1,
  parameter int LEN_W   = $clog2(PACK_W + 1)
) (
  input  logic [1:0]        asz_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [PACK_W-1:0] word_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              valid_o
);
  logic [LEN_W-1:0]  abits;
  logic [ADDR_W-1:0] amask;

  always_comb begin
    valid_o = 1'b1;
    case (asz_e'(asz_i))
      ASZ_SHORT: abits = LEN_W'(A_SHORT);
      ASZ_MID:   abits = LEN_W'(A_MID);
      ASZ_LONG:  abits = LEN_W'(ADDR_W);
      default: begin
        abits   = LEN_W'(ADDR_W);
        valid_o = 1'b0;
      end
    endcase
    // full-width address wraps the shift to zero, so the mask becomes all ones
    amask  = (ADDR_W'(1) << abits) - ADDR_W'(1);
    word_o = (PACK_W'(data_i) << (abits + LEN_W'(1)))
           | (PACK_W'(addr_i & amask) << 1)
           | PACK_W'(1);
    len_o  = abits + LEN_W'(DATA_W + 1);
  end
endmodule

// File: rtl/crc4_step.sv
module crc4_step #(
  parameter int          CRC_W = 4,
  parameter logic [CRC_W-1:0] POLY = 4'hC
) (
  input  logic [CRC_W-1:0] crc_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);
  logic fb;
  assign fb = crc_i[0] ^ bit_i;

  for (genvar i = 0; i < CRC_W - 1; i++) begin : g_tap
    assign crc_o[i] = crc_i[i+1] ^ (fb & POLY[i]);
  end
  assign crc_o[CRC_W-1] = fb & POLY[CRC_W-1];
endmodule

// File: rtl/cmd_crc4.sv
module cmd_crc4
  import crc4_pkg::*;
#(
  parameter int          ADDR_W  = 10,
  parameter int          DATA_W  = 8,
  parameter int          A_SHORT = 5,
  parameter int          A_MID   = 8,
  parameter int          CRC_W   = 4,
  parameter logic [CRC_W-1:0] POLY = 4'hC,
  parameter logic [CRC_W-1:0] SEED = 4'h5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        asz_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o,
  output logic              done_o
);
  localparam int PACK_W = ADDR_W + DATA_W + 1;
  localparam int LEN_W  = $clog2(PACK_W + 1);

  logic [PACK_W-1:0] pk_word;
  logic [LEN_W-1:0]  pk_len;
  logic              pk_valid;
  logic [PACK_W-1:0] sh_q;
  logic [LEN_W-1:0]  cnt_q;
  logic              busy_q;
  logic [CRC_W-1:0]  acc_q, acc_nx, crc_q;
  logic              done_q;

  crc4_pack #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .A_SHORT(A_SHORT), .A_MID(A_MID),
    .PACK_W(PACK_W), .LEN_W(LEN_W)
  ) u_pack (
    .asz_i(asz_i), .addr_i(addr_i), .data_i(data_i),
    .word_o(pk_word), .len_o(pk_len), .valid_o(pk_valid)
  );

  crc4_step #(.CRC_W(CRC_W), .POLY(POLY)) u_step (
    .crc_i(acc_q), .bit_i(sh_q[0]), .crc_o(acc_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      acc_q  <= '0;
      crc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && pk_valid) begin
        acc_q  <= SEED;
        sh_q   <= pk_word;
        cnt_q  <= pk_len;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        acc_q <= acc_nx;
        sh_q  <= sh_q >> 1;
        cnt_q <= cnt_q - LEN_W'(1);
        if (cnt_q == LEN_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          crc_q  <= acc_nx;
        end
      end
    end
  end

  assign crc_o  = crc_q;
  assign done_o = done_q;

  // R5: the completion flag never lasts two cycles
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R5: a run in progress always has bits left to process
  assert_busy_count_R5: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q != '0));

  // R4: an accepted start loads one of the three legal string lengths
  assert_len_R4: assert property (@(posedge clk) disable iff (rst)
    (start_i && pk_valid) |=> (cnt_q == LEN_W'(A_SHORT + DATA_W + 1)
                            || cnt_q == LEN_W'(A_MID + DATA_W + 1)
                            || cnt_q == LEN_W'(ADDR_W + DATA_W + 1)));

  // R6: the result only moves together with the done flag
  assert_crc_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !done_o |=> (done_o || $stable(crc_o)));

  // R7: a reserved-size start on an idle block leaves it idle
  assert_reserved_R7: assert property (@(posedge clk) disable iff (rst)
    (start_i && asz_i == 2'd3 && !busy_q) |=> !busy_q);

  // R8: an accepted start is never followed directly by a done pulse
  assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
    (start_i && pk_valid) |=> !done_o);
endmodule

// File: tb/test_cmd_crc4.sv
`timescale 1ns/1ps
module test_cmd_crc4;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [1:0] asz_i = 2'd0;
  logic [9:0] addr_i = '0;
  logic [7:0] data_i = '0;
  logic [3:0] crc_o;
  logic       done_o;

  int n_chk = 0;
  int n_bad = 0;

  cmd_crc4 i_cmd_crc4 (
    .clk(clk), .rst(rst), .start_i(start_i), .asz_i(asz_i),
    .addr_i(addr_i), .data_i(data_i), .crc_o(crc_o), .done_o(done_o)
  );

  always #10 clk = ~clk;

  function automatic int abits_ref(input logic [1:0] m);
    case (m)
      2'd0: return 5;
      2'd1: return 8;
      default: return 10;
    endcase
  endfunction

  function automatic logic [3:0] crc_ref(input logic [1:0] m, input logic [9:0] a, input logic [7:0] d);
    int ab = abits_ref(m);
    logic [31:0] w = (32'(d) << (ab + 1)) | ((32'(a) & ((32'd1 << ab) - 1)) << 1) | 32'd1;
    logic [3:0] c = 4'h5;
    for (int i = 0; i < ab + 9; i++) begin
      logic fb = c[0] ^ w[i];
      c = c >> 1;
      if (fb) c = c ^ 4'hC;
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic launch(input logic [1:0] m, input logic [9:0] a, input logic [7:0] d);
    start_i = 1'b1; asz_i = m; addr_i = a; data_i = d;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // called at the first negedge after the start edge
  task automatic await_run(input logic [1:0] m, input logic [9:0] a, input logic [7:0] d,
                           input string req, input bit scramble);
    int cyc = 0;
    int len = abits_ref(m) + 9;
    logic [3:0] exp = crc_ref(m, a, d);
    check(done_o == 1'b0, "R8", int'(done_o), 0);
    while (!done_o && cyc < 40) begin
      if (scramble) begin
        addr_i = 10'($urandom); data_i = 8'($urandom); asz_i = 2'($urandom_range(0, 2));
      end
      @(negedge clk);
      cyc++;
    end
    check(cyc == len, "R5", cyc, len);
    check(crc_o == exp, req, int'(crc_o), int'(exp));
    @(negedge clk);
    check(done_o == 1'b0, "R5", int'(done_o), 0);
    check(crc_o == exp, "R6", int'(crc_o), int'(exp));
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed = $urandom(32'd4711);
    logic [3:0] prev;
    repeat (3) @(negedge clk);
    check(crc_o == 4'h0, "R1", int'(crc_o), 0);
    check(done_o == 1'b0, "R1", int'(done_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check(crc_o == 4'h0 && done_o == 1'b0, "R1", int'(crc_o), 0);

    // directed corners per size (R2, R3, R4)
    for (int m = 0; m < 3; m++) begin
      launch(2'(m), 10'h000, 8'h00); await_run(2'(m), 10'h000, 8'h00, "R3", 1'b0);
      launch(2'(m), 10'h3FF, 8'hFF); await_run(2'(m), 10'h3FF, 8'hFF, "R2", 1'b0);
      launch(2'(m), 10'h155, 8'hA5); await_run(2'(m), 10'h155, 8'hA5, "R4", 1'b0);
    end

    // reserved size ignored (R7)
    prev = crc_o;
    launch(2'd3, 10'h2AA, 8'h3C);
    for (int k = 0; k < 30; k++) begin
      check(done_o == 1'b0, "R7", int'(done_o), 0);
      @(negedge clk);
    end
    check(crc_o == prev, "R7", int'(crc_o), int'(prev));

    // restart mid-run (R8)
    launch(2'd2, 10'h123, 8'h45);
    repeat (4) @(negedge clk);
    launch(2'd0, 10'h01A, 8'hC3);
    await_run(2'd0, 10'h01A, 8'hC3, "R8", 1'b0);

    // restart on the finishing edge of the first run (R8)
    launch(2'd1, 10'h0F0, 8'h99);
    repeat (17 - 1) begin
      check(done_o == 1'b0, "R8", int'(done_o), 0);
      @(negedge clk);
    end
    launch(2'd2, 10'h2C7, 8'h5E);
    await_run(2'd2, 10'h2C7, 8'h5E, "R8", 1'b0);

    // inputs wiggled during the run (R9)
    for (int k = 0; k < 6; k++) begin
      logic [1:0] m = 2'($urandom_range(0, 2));
      logic [9:0] a = 10'($urandom);
      logic [7:0] d = 8'($urandom);
      launch(m, a, d); await_run(m, a, d, "R9", 1'b1);
    end

    // random traffic (R2, R3)
    for (int k = 0; k < 150; k++) begin
      logic [1:0] m = 2'($urandom_range(0, 2));
      logic [9:0] a = 10'($urandom);
      logic [7:0] d = 8'($urandom);
      launch(m, a, d); await_run(m, a, d, "R3", 1'b0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule